// File: doc/BRIEF.md
# Subset Instruction Decoder for a Single-Cycle Datapath

This block turns one 32-bit instruction word into every control value a single-cycle datapath needs in the same cycle. It is purely combinational. It has no clock, no reset and no stored state, so its outputs follow the instruction input directly. It recognises sixteen operations:

- three-register arithmetic: add, subtract and set-if-less-than
- register jump
- immediate add, immediate OR and immediate set-if-less-than
- upper-immediate load
- word and byte loads and stores
- equal and not-equal branches
- plain jump and jump-with-link

Every other encoding is flagged as illegal, and on an illegal encoding no write, memory or control-flow strobe is raised.

The decoder also forms the 32-bit immediate. It sign-extends it, zero-extends it, or places it in the upper half, according to the operation. The datapath around it uses the outputs as follows: the register file reads the two source addresses; the write-back stage uses the write address and enable; the ALU takes the operation code; the fetch unit uses the branch, jump and link flags.

Top module: `mdec_top`

## Requirements
- R1: `rs_addr_o` always equals instruction bits [25:21] and `rt_addr_o` always equals bits [20:16], whatever the opcode.
- R2: With opcode 0 and function 32, 34 or 42 (add, subtract, set-if-less-than), `reg_we_o`=1, `dst_sel_o`=1 (rd), `wr_addr_o`=bits [15:11], and `alu_op_o` is 0 (add), 1 (subtract) or 3 (less-than) respectively.
- R3: Opcodes 8, 13, 10, 15, 35 and 32 set `reg_we_o`=1, `dst_sel_o`=0 (rt) and `wr_addr_o`=bits [20:16]. The `alu_op_o` values are 0, 2 (OR), 3, 4 (pass immediate), 0 and 0 respectively.
- R4: `imm_mode_o` is 1 for opcode 13 and gives `imm_o`={16'h0, imm}. It is 2 for opcode 15 and gives `imm_o`={imm, 16'h0}. For all other encodings it is 0 and `imm_o` is imm[15] copied into the upper 16 bits. Here imm is bits [15:0].
- R5: Opcode 35 (word) and opcode 32 (byte) raise `mem_rd_o`. Opcode 43 (word) and opcode 40 (byte) raise `mem_wr_o` with `reg_we_o`=0. `mem_byte_o`=1 only for opcodes 32 and 40.
- R6: Opcode 4 gives `branch_o`=1 and `branch_ne_o`=0. Opcode 5 gives `branch_o`=1 and `branch_ne_o`=1. Both give `alu_op_o`=1 and `reg_we_o`=0.
- R7: Opcode 2 gives `jump_o`=1 with no register write. Opcode 3 gives `jump_o`=1, `link_o`=1, `reg_we_o`=1, `dst_sel_o`=2 and `wr_addr_o`=31.
- R8: Opcode 0 with function 8 gives `jump_reg_o`=1, `dst_sel_o`=1, and no register write or memory strobe.
- R9: Any opcode outside {0,2,3,4,5,8,10,13,15,32,35,40,43}, or opcode 0 with a function outside {8,32,34,42}, gives `illegal_o`=1. It forces `reg_we_o`, both memory strobes, `branch_o`, `branch_ne_o`, `jump_o`, `jump_reg_o` and `link_o` to 0, and gives `dst_sel_o`=0 and `alu_op_o`=0.
- R10: `mem_rd_o` and `mem_wr_o` are never both 1, and at most one of `branch_o`, `jump_o` and `jump_reg_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs_addr_o | output | 5 | First source register address |
| rt_addr_o | output | 5 | Second source register address |
| wr_addr_o | output | 5 | Destination register address |
| reg_we_o | output | 1 | Register write enable |
| dst_sel_o | output | 2 | Destination choice: 0 rt, 1 rd, 2 link register |
| alu_op_o | output | 3 | ALU operation: 0 add, 1 sub, 2 or, 3 less-than, 4 pass immediate |
| imm_o | output | 32 | Extended immediate |
| imm_mode_o | output | 2 | Extension: 0 sign, 1 zero, 2 upper half |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_byte_o | output | 1 | Access size: 1 byte, 0 word |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch taken on inequality |
| jump_o | output | 1 | Direct jump |
| jump_reg_o | output | 1 | Jump through register |
| link_o | output | 1 | Return address is written |
| illegal_o | output | 1 | Encoding outside the subset |

## Verification
The block holds no state, so the only wrong internal value it can carry is a misclassified instruction. That error shows on the ports in the same evaluation as the offending input. A wrong class produces a whole set of wrong flags at once. A wrong extension mode corrupts only `imm_o`. The bench therefore compares every output against an independent model for each instruction it applies. It applies random fields under every opcode and directed boundary immediates, so that both whole-set errors and immediate-only errors are caught.

// File: rtl/mdec_pkg.sv
// Package mdec_pkg: shared encodings for the subset instruction decoder.
// Assumes the fixed 32-bit instruction layout, with the opcode in the top six bits.
package mdec_pkg;

    localparam int OPW   = 6;
    localparam int FNW   = 6;
    localparam int REGW  = 5;
    localparam int IMMW  = 16;

    // Primary opcode values
    localparam logic [OPW-1:0] OP_RTYPE = 6'd0;
    localparam logic [OPW-1:0] OP_J     = 6'd2;
    localparam logic [OPW-1:0] OP_JAL   = 6'd3;
    localparam logic [OPW-1:0] OP_BEQ   = 6'd4;
    localparam logic [OPW-1:0] OP_BNE   = 6'd5;
    localparam logic [OPW-1:0] OP_ADDI  = 6'd8;
    localparam logic [OPW-1:0] OP_SLTI  = 6'd10;
    localparam logic [OPW-1:0] OP_ORI   = 6'd13;
    localparam logic [OPW-1:0] OP_LUI   = 6'd15;
    localparam logic [OPW-1:0] OP_LB    = 6'd32;
    localparam logic [OPW-1:0] OP_LW    = 6'd35;
    localparam logic [OPW-1:0] OP_SB    = 6'd40;
    localparam logic [OPW-1:0] OP_SW    = 6'd43;

    // Function codes under the register-format opcode
    localparam logic [FNW-1:0] FN_JR  = 6'd8;
    localparam logic [FNW-1:0] FN_ADD = 6'd32;
    localparam logic [FNW-1:0] FN_SUB = 6'd34;
    localparam logic [FNW-1:0] FN_SLT = 6'd42;

    typedef enum logic [4:0] {
        IC_ILLEGAL, IC_ADD, IC_SUB, IC_SLT, IC_JR,
        IC_ADDI, IC_ORI, IC_SLTI, IC_LUI,
        IC_LW, IC_LB, IC_SW, IC_SB,
        IC_BEQ, IC_BNE, IC_J, IC_JAL
    } iclass_e;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_OR   = 3'd2,
        ALU_SLT  = 3'd3,
        ALU_PASS = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_e;

    typedef enum logic [1:0] {
        DST_RT   = 2'd0,
        DST_RD   = 2'd1,
        DST_LINK = 2'd2
    } dst_e;

    typedef struct packed {
        logic    reg_we;
        dst_e    dst;
        alu_op_e alu;
        ext_e    ext;
        logic    mem_rd;
        logic    mem_wr;
        logic    mem_byte;
        logic    branch;
        logic    branch_ne;
        logic    jump;
        logic    jump_reg;
        logic    link;
        logic    illegal;
    } ctrl_t;

endpackage

// File: rtl/mdec_classify.sv
// Module mdec_classify: maps opcode and function code to one instruction class.
// Assumes the function code is meaningful only under the register-format opcode;
// every unlisted combination becomes IC_ILLEGAL.
module mdec_classify
    import mdec_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [FNW-1:0] funct_i,
    output iclass_e        cls_o
);

    // Select the class from the primary opcode, then the function code
    always_comb begin
        cls_o = IC_ILLEGAL;
        unique case (op_i)
            OP_RTYPE: begin
                unique case (funct_i)
                    FN_ADD:  cls_o = IC_ADD;
                    FN_SUB:  cls_o = IC_SUB;
                    FN_SLT:  cls_o = IC_SLT;
                    FN_JR:   cls_o = IC_JR;
                    default: cls_o = IC_ILLEGAL;
                endcase
            end
            OP_ADDI: cls_o = IC_ADDI;
            OP_ORI:  cls_o = IC_ORI;
            OP_SLTI: cls_o = IC_SLTI;
            OP_LUI:  cls_o = IC_LUI;
            OP_LW:   cls_o = IC_LW;
            OP_LB:   cls_o = IC_LB;
            OP_SW:   cls_o = IC_SW;
            OP_SB:   cls_o = IC_SB;
            OP_BEQ:  cls_o = IC_BEQ;
            OP_BNE:  cls_o = IC_BNE;
            OP_J:    cls_o = IC_J;
            OP_JAL:  cls_o = IC_JAL;
            default: cls_o = IC_ILLEGAL;
        endcase
    end

endmodule

// File: rtl/mdec_ctrl.sv
// Module mdec_ctrl: expands an instruction class into the datapath control set.
// Assumes the class is already resolved; an illegal class keeps every strobe low.
module mdec_ctrl
    import mdec_pkg::*;
(
    input  iclass_e cls_i,
    output ctrl_t   ctrl_o
);

    // Start from a safe default and raise only what the class needs
    always_comb begin
        ctrl_o           = '0;
        ctrl_o.dst       = DST_RT;
        ctrl_o.alu       = ALU_ADD;
        ctrl_o.ext       = EXT_SIGN;
        unique case (cls_i)
            IC_ADD:  begin ctrl_o.reg_we = 1'b1; ctrl_o.dst = DST_RD; end
            IC_SUB:  begin ctrl_o.reg_we = 1'b1; ctrl_o.dst = DST_RD; ctrl_o.alu = ALU_SUB; end
            IC_SLT:  begin ctrl_o.reg_we = 1'b1; ctrl_o.dst = DST_RD; ctrl_o.alu = ALU_SLT; end
            IC_JR:   begin ctrl_o.jump_reg = 1'b1; ctrl_o.dst = DST_RD; end
            IC_ADDI: ctrl_o.reg_we = 1'b1;
            IC_ORI:  begin ctrl_o.reg_we = 1'b1; ctrl_o.alu = ALU_OR; ctrl_o.ext = EXT_ZERO; end
            IC_SLTI: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu = ALU_SLT; end
            IC_LUI:  begin ctrl_o.reg_we = 1'b1; ctrl_o.alu = ALU_PASS; ctrl_o.ext = EXT_UPPER; end
            IC_LW:   begin ctrl_o.reg_we = 1'b1; ctrl_o.mem_rd = 1'b1; end
            IC_LB:   begin ctrl_o.reg_we = 1'b1; ctrl_o.mem_rd = 1'b1; ctrl_o.mem_byte = 1'b1; end
            IC_SW:   ctrl_o.mem_wr = 1'b1;
            IC_SB:   begin ctrl_o.mem_wr = 1'b1; ctrl_o.mem_byte = 1'b1; end
            IC_BEQ:  begin ctrl_o.branch = 1'b1; ctrl_o.alu = ALU_SUB; end
            IC_BNE:  begin ctrl_o.branch = 1'b1; ctrl_o.branch_ne = 1'b1; ctrl_o.alu = ALU_SUB; end
            IC_J:    ctrl_o.jump = 1'b1;
            IC_JAL:  begin ctrl_o.jump = 1'b1; ctrl_o.link = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.dst = DST_LINK; end
            default: ctrl_o.illegal = 1'b1;
        endcase
    end

    // Check the control set for strobe combinations that must never occur
    always_comb begin
        // R10
        mem_excl_chk: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr))
            else $error("memory read and write raised together");
        // R10
        flow_excl_chk: assert ($onehot0({ctrl_o.branch, ctrl_o.jump, ctrl_o.jump_reg}))
            else $error("more than one control-flow flag raised");
        // R5
        byte_needs_mem_chk: assert (!ctrl_o.mem_byte || ctrl_o.mem_rd || ctrl_o.mem_wr)
            else $error("byte size flag without a memory access");
    end

endmodule

// File: rtl/mdec_immgen.sv
// Module mdec_immgen: widens the instruction's immediate field to the data width.
// Assumes XLEN is at least twice IMMW so that the upper-half placement fits.
module mdec_immgen
    import mdec_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IW   = IMMW
) (
    input  logic [IW-1:0]   imm_i,
    input  ext_e            ext_i,
    output logic [XLEN-1:0] imm_o
);

    localparam int HI_W = XLEN - IW;

    // Choose sign extension, zero extension or upper-half placement
    always_comb begin
        unique case (ext_i)
            EXT_ZERO:  imm_o = {{HI_W{1'b0}}, imm_i};
            EXT_UPPER: imm_o = {imm_i, {HI_W{1'b0}}};
            default:   imm_o = {{HI_W{imm_i[IW-1]}}, imm_i};
        endcase
    end

    // Check each extension mode against the raw field
    always_comb begin
        // R4
        upper_low_clear_chk: assert (ext_i != EXT_UPPER || imm_o[HI_W-1:0] == '0)
            else $error("upper placement left low bits set");
        // R4
        zero_ext_chk: assert (ext_i != EXT_ZERO || imm_o[XLEN-1:IW] == '0)
            else $error("zero extension set upper bits");
        // R4
        sign_keep_chk: assert (ext_i != EXT_SIGN || imm_o[IW-1:0] == imm_i)
            else $error("sign extension altered the low field");
    end

endmodule

// File: rtl/mdec_regsel.sv
// Module mdec_regsel: extracts the source addresses and picks the destination.
// Assumes the fixed field positions of the instruction word; the link register
// index is a parameter.
module mdec_regsel
    import mdec_pkg::*;
#(
    parameter int RW       = REGW,
    parameter int LINK_REG = 31
) (
    input  logic [31:0]   instr_i,
    input  dst_e          dst_i,
    output logic [RW-1:0] rs_addr_o,
    output logic [RW-1:0] rt_addr_o,
    output logic [RW-1:0] wr_addr_o
);

    localparam logic [RW-1:0] LINK_IDX = RW'(LINK_REG);

    // Source fields sit at fixed positions in every format
    always_comb begin
        rs_addr_o = instr_i[25:21];
        rt_addr_o = instr_i[20:16];
    end

    // Destination is rt, rd or the link register
    always_comb begin
        unique case (dst_i)
            DST_RD:   wr_addr_o = instr_i[15:11];
            DST_LINK: wr_addr_o = LINK_IDX;
            default:  wr_addr_o = instr_i[20:16];
        endcase
    end

    // Check destination choice against the instruction fields
    always_comb begin
        // R7
        link_idx_chk: assert (dst_i != DST_LINK || wr_addr_o == LINK_IDX)
            else $error("link destination not the link register");
        // R3
        rt_dst_chk: assert (dst_i != DST_RT || wr_addr_o == rt_addr_o)
            else $error("rt destination mismatch");
    end

endmodule

// File: rtl/mdec_top.sv
// Module mdec_top: combinational decoder for the supported instruction subset.
// Assumes one instruction per cycle is presented by the fetch stage; holds no
// state, so no clock or reset is needed.
module mdec_top
    import mdec_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RW       = REGW,
    parameter int LINK_REG = 31
) (
    input  logic [31:0]     instr_i,
    output logic [RW-1:0]   rs_addr_o,
    output logic [RW-1:0]   rt_addr_o,
    output logic [RW-1:0]   wr_addr_o,
    output logic            reg_we_o,
    output logic [1:0]      dst_sel_o,
    output logic [2:0]      alu_op_o,
    output logic [XLEN-1:0] imm_o,
    output logic [1:0]      imm_mode_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic            mem_byte_o,
    output logic            branch_o,
    output logic            branch_ne_o,
    output logic            jump_o,
    output logic            jump_reg_o,
    output logic            link_o,
    output logic            illegal_o
);

    iclass_e cls;
    ctrl_t   ctrl;

    mdec_classify u_classify (
        .op_i    (instr_i[31:26]),
        .funct_i (instr_i[5:0]),
        .cls_o   (cls)
    );

    mdec_ctrl u_ctrl (
        .cls_i  (cls),
        .ctrl_o (ctrl)
    );

    mdec_immgen #(.XLEN(XLEN), .IW(IMMW)) u_immgen (
        .imm_i (instr_i[15:0]),
        .ext_i (ctrl.ext),
        .imm_o (imm_o)
    );

    mdec_regsel #(.RW(RW), .LINK_REG(LINK_REG)) u_regsel (
        .instr_i   (instr_i),
        .dst_i     (ctrl.dst),
        .rs_addr_o (rs_addr_o),
        .rt_addr_o (rt_addr_o),
        .wr_addr_o (wr_addr_o)
    );

    // Drive the flat control ports from the control record
    always_comb begin
        reg_we_o    = ctrl.reg_we;
        dst_sel_o   = ctrl.dst;
        alu_op_o    = ctrl.alu;
        imm_mode_o  = ctrl.ext;
        mem_rd_o    = ctrl.mem_rd;
        mem_wr_o    = ctrl.mem_wr;
        mem_byte_o  = ctrl.mem_byte;
        branch_o    = ctrl.branch;
        branch_ne_o = ctrl.branch_ne;
        jump_o      = ctrl.jump;
        jump_reg_o  = ctrl.jump_reg;
        link_o      = ctrl.link;
        illegal_o   = ctrl.illegal;
    end

    // Check that an illegal encoding reaches no strobe
    always_comb begin
        // R9
        illegal_quiet_chk: assert (!illegal_o ||
            !(reg_we_o || mem_rd_o || mem_wr_o || branch_o || jump_o || jump_reg_o || link_o))
            else $error("illegal encoding raised a strobe");
        // R7
        link_writes_chk: assert (!link_o || (reg_we_o && jump_o))
            else $error("link without write and jump");
        // R2
        rd_dst_chk: assert (!(reg_we_o && dst_sel_o == 2'd1) || wr_addr_o == instr_i[15:11])
            else $error("rd destination mismatch");
    end

endmodule

// File: tb/mdec_top_tb.sv
module mdec_top_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] instr;
    logic [4:0]  rs_a, rt_a, wr_a;
    logic        we, mrd, mwr, mbyte, br, brne, jmp, jr, lnk, ill;
    logic [1:0]  dst, mode;
    logic [2:0]  alu;
    logic [31:0] imm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    mdec_top u_dut (
        .instr_i(instr), .rs_addr_o(rs_a), .rt_addr_o(rt_a), .wr_addr_o(wr_a),
        .reg_we_o(we), .dst_sel_o(dst), .alu_op_o(alu), .imm_o(imm), .imm_mode_o(mode),
        .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_byte_o(mbyte), .branch_o(br),
        .branch_ne_o(brne), .jump_o(jmp), .jump_reg_o(jr), .link_o(lnk), .illegal_o(ill)
    );

    // Expected outputs packed as rs,rt,wr,we,dst,alu,imm,mode,mrd,mwr,byte,br,brne,j,jr,link,ill
    function automatic logic [63:0] model(input logic [31:0] i);
        logic [5:0] op, f;
        logic e_we, e_mrd, e_mwr, e_by, e_br, e_bne, e_j, e_jr, e_ln, e_ill;
        logic [1:0] e_dst, e_md;
        logic [2:0] e_alu;
        logic [4:0] e_wr;
        logic [31:0] e_imm;
        op = i[31:26]; f = i[5:0];
        {e_we, e_mrd, e_mwr, e_by, e_br, e_bne, e_j, e_jr, e_ln, e_ill} = '0;
        e_dst = 0; e_md = 0; e_alu = 0;
        case (op)
            6'd0: case (f)
                6'd32: begin e_we = 1; e_dst = 1; end
                6'd34: begin e_we = 1; e_dst = 1; e_alu = 1; end
                6'd42: begin e_we = 1; e_dst = 1; e_alu = 3; end
                6'd8:  begin e_dst = 1; e_jr = 1; end
                default: e_ill = 1;
            endcase
            6'd8:  e_we = 1;
            6'd13: begin e_we = 1; e_alu = 2; e_md = 1; end
            6'd10: begin e_we = 1; e_alu = 3; end
            6'd15: begin e_we = 1; e_alu = 4; e_md = 2; end
            6'd35: begin e_we = 1; e_mrd = 1; end
            6'd32: begin e_we = 1; e_mrd = 1; e_by = 1; end
            6'd43: e_mwr = 1;
            6'd40: begin e_mwr = 1; e_by = 1; end
            6'd4:  begin e_br = 1; e_alu = 1; end
            6'd5:  begin e_br = 1; e_bne = 1; e_alu = 1; end
            6'd2:  e_j = 1;
            6'd3:  begin e_j = 1; e_ln = 1; e_we = 1; e_dst = 2; end
            default: e_ill = 1;
        endcase
        e_wr = (e_dst == 1) ? i[15:11] : (e_dst == 2) ? 5'd31 : i[20:16];
        e_imm = (e_md == 1) ? {16'h0, i[15:0]} :
                (e_md == 2) ? {i[15:0], 16'h0} : {{16{i[15]}}, i[15:0]};
        return {i[25:21], i[20:16], e_wr, e_we, e_dst, e_alu, e_imm, e_md,
                e_mrd, e_mwr, e_by, e_br, e_bne, e_j, e_jr, e_ln, e_ill};
    endfunction

    // Requirement tag for the instruction's class
    function automatic string tag_of(input logic [31:0] i);
        case (i[31:26])
            6'd0: case (i[5:0])
                6'd32, 6'd34, 6'd42: return "R1 R2";
                6'd8: return "R1 R8";
                default: return "R1 R9";
            endcase
            6'd8, 6'd10: return "R1 R3 R4";
            6'd13, 6'd15: return "R3 R4";
            6'd35, 6'd32, 6'd43, 6'd40: return "R3 R5";
            6'd4, 6'd5: return "R6";
            6'd2, 6'd3: return "R7";
            default: return "R1 R9";
        endcase
    endfunction

    function automatic bit legal_op(input logic [5:0] op);
        return op inside {6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd10, 6'd13,
                          6'd15, 6'd32, 6'd35, 6'd40, 6'd43};
    endfunction

    task automatic apply(input logic [31:0] i);
        logic [63:0] act, exp;
        @(posedge clk);
        instr = i;
        @(negedge clk);
        act = {rs_a, rt_a, wr_a, we, dst, alu, imm, mode,
               mrd, mwr, mbyte, br, brne, jmp, jr, lnk, ill};
        exp = model(i);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s instr=%h actual=%h expected=%h", tag_of(i), i, act, exp);
        end
        // R10: strobe exclusivity seen at the ports
        checks++;
        if ((mrd && mwr) || !$onehot0({br, jmp, jr})) begin
            errors++;
            $display("FAIL R10 instr=%h actual=%b%b_%b%b%b expected=exclusive",
                     i, mrd, mwr, br, jmp, jr);
        end
    endtask

    function automatic logic [31:0] rand_instr();
        logic [5:0] legal [16];
        logic [31:0] r;
        int k;
        legal = '{6'd0, 6'd0, 6'd0, 6'd0, 6'd8, 6'd13, 6'd10, 6'd15,
                  6'd35, 6'd32, 6'd43, 6'd40, 6'd4, 6'd5, 6'd2, 6'd3};
        r = $urandom;
        k = int'($urandom % 20);
        if (k < 4) begin
            r[31:26] = 6'd0;
            case (k) 0: r[5:0] = 6'd32; 1: r[5:0] = 6'd34; 2: r[5:0] = 6'd42; default: r[5:0] = 6'd8; endcase
        end else if (k < 16) begin
            r[31:26] = legal[k];
        end else if (k < 18) begin
            do r[31:26] = 6'($urandom); while (legal_op(r[31:26]));
        end else begin
            r[31:26] = 6'd0;
            do r[5:0] = 6'($urandom); while (r[5:0] inside {6'd8, 6'd32, 6'd34, 6'd42});
        end
        return r;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        instr = 32'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R9: all-zero word (function 0) is outside the subset
        apply(32'h0000_0000);
        // R7: link with widest target
        apply({6'd3, 26'h3FF_FFFF});
        // R4: upper placement of all ones, zero and sign extension of 0x8000
        apply({6'd15, 5'd0, 5'd9, 16'hFFFF});
        apply({6'd13, 5'd4, 5'd9, 16'h8000});
        apply({6'd8, 5'd4, 5'd9, 16'h8000});
        apply({6'd10, 5'd31, 5'd1, 16'h7FFF});
        // R5: byte load and byte store
        apply({6'd32, 5'd3, 5'd7, 16'h0001});
        apply({6'd40, 5'd3, 5'd7, 16'hFFFE});
        // R6: not-equal branch
        apply({6'd5, 5'd16, 5'd17, 16'hFFFC});
        // R8: register jump through register 31
        apply({6'd0, 5'd31, 15'd0, 6'd8});
        // R9: highest opcode and bad function
        apply({6'h3F, 26'h155_5555});
        apply({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd33});
        // R2: rd field at all ones
        apply({6'd0, 5'd1, 5'd2, 5'd31, 5'd0, 6'd42});
        for (int n = 0; n < 3000; n++) apply(rand_instr());
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule